// File: doc/BRIEF.md
# Display Controller Register Window Decoder

This block is the memory-mapped register front end of a display controller. A simple little-endian bus presents an address, a write strobe, an access size of 1, 2 or 4 bytes and 32-bit write data. The block splits one address window into four sub-windows. The first is a read-only byte array that identifies the attached monitor. The second is a relocated bank of 8-bit legacy I/O ports. The third is an indexed 16-bit mode-setting register file that is reached by direct addressing. The fourth is a small extension register set that reports its own span and holds the framebuffer byte-order flag.

The legacy port bank and the indexed register file are stub register files inside the block. Among the legacy ports, one index port and one data port drive an indirect sequencer array. A multi-byte write applies its bytes from the lowest lane upward. As a result, one 16-bit write can load the index and then store the data under the new index. Read data is registered. It appears on the cycle after the read strobe and holds until the next read.

Top module: `disp_win_decode`

## Requirements
- R1: In the legacy port sub-window (0x400 to 0x41F), local offset N addresses port 0x3C0+N. A 1-byte read returns the byte last written to that port. Every port reads 0 after reset.
- R2: In a legacy read of S bytes at offset N, byte lane k (bits 8k+7:8k) carries port N+k. Lanes that fall past offset 31 read 0, and writes to those lanes are dropped.
- R3: Legacy offset 4 is the sequencer index port and offset 5 is the sequencer data port. The data port reads and writes entry (index mod 8) of an 8-entry array. A multi-byte write applies its lanes in ascending order, so a 16-bit write of 0xDDII at offset 4 sets the index to II and then writes DD to entry II.
- R4: In the indexed sub-window (0x500 to 0x5FF), local offset o selects register o>>1 of 16 registers of 16 bits each. Writes take bits 15:0 of the write data. Reads return the register zero-extended to 32 bits. Index values of 16 and above read 0, and writes to them are ignored.
- R5: A 4-byte read at 0x600 returns the extension span 0x100. Any other extension offset except 0x604 reads 0.
- R6: A 4-byte read at 0x604 returns 0xBEBEBEBE while the byte-order flag is set and 0x1E1E1E1E while it is clear. The flag is also driven on output fb_big_endian.
- R7: A 4-byte write of exactly 0xBEBEBEBE to 0x604 sets the flag, and a write of exactly 0x1E1E1E1E clears it. Any other value leaves the flag unchanged.
- R8: Extension accesses whose size is not 4 bytes read 0 and change nothing.
- R9: Addresses 0x000 to 0x17F hold 384 read-only identification bytes. Byte i is 0x00,0xFF,0xFF,0xFF,0xFF,0xFF,0xFF,0x00 for i<8, and (37*i+11) mod 256 for all other i. Multi-byte reads are little-endian, and lanes past 0x17F read 0. Writes are ignored.
- R10: With the extension set disabled, dev_revision is 1, the flag stays 0 and the extension window reads 0. With it enabled, dev_revision is 2. With the identification array disabled, its window reads 0.
- R11: Reads of addresses outside every enabled sub-window (for example 0x180, 0x420, 0x700) return 0, and writes there change nothing.
- R12: bus_rdata is loaded on the clock edge of a read strobe and holds through write and idle cycles. Reset clears bus_rdata to 0 and the byte-order flag to little-endian.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| bus_wdata | input | 32 | Write data, little-endian lanes |
| bus_rdata | output | 32 | Registered read data |
| fb_big_endian | output | 1 | Framebuffer byte-order flag |
| dev_revision | output | 8 | Reported device revision |

## Verification
The properties assume that every strobe lasts exactly one cycle and carries a size of 1, 2 or 4 bytes. They also assume that a byte-order access is recognised only at the exact address 0x604 with a 4-byte size. The stimulus drives every access through a single task that raises the strobe for one cycle with a legal size, and it changes inputs only on the falling edge. Odd sizes at the extension register are kept to 2 bytes, which is legal on the bus but rejected by that sub-window.

// File: rtl/disp_win_pkg.sv
// Package: shared constants and the identification content generator.
// Assumes byte addressing and 32-bit little-endian data lanes.
package disp_win_pkg;

    localparam logic [31:0] BO_BIG_CODE    = 32'hBEBE_BEBE;
    localparam logic [31:0] BO_LITTLE_CODE = 32'h1E1E_1E1E;
    localparam int unsigned LANES          = 4;

    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_ID,
        WIN_PORT,
        WIN_IDX,
        WIN_EXT
    } win_e;

    // Identification byte i: fixed 8-byte header, then an arithmetic fill.
    function automatic logic [7:0] id_byte(input logic [31:0] i);
        logic [31:0] fill;
        if (i == 32'd0 || i == 32'd7) begin
            return 8'h00;
        end else if (i < 32'd8) begin
            return 8'hFF;
        end
        fill = (i * 32'd37) + 32'd11;
        return fill[7:0];
    endfunction

endpackage

// File: rtl/disp_port_file.sv
// Legacy byte-port bank: NPORTS byte ports, plus an indirect sequencer
// array reached through an index port and a data port.
// Assumes size is 1, 2 or 4. Write lanes are applied lowest first, so a
// lane hitting the data port sees an index written by an earlier lane.
module disp_port_file #(
    parameter int unsigned NPORTS    = 32,
    parameter int unsigned SEQ_DEPTH = 8,
    parameter int unsigned IDX_OFS   = 4,
    parameter int unsigned DATA_OFS  = 5,
    localparam int unsigned OFS_W    = $clog2(NPORTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] ofs,
    input  logic [2:0]       size,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);
    import disp_win_pkg::*;

    localparam int unsigned PW    = OFS_W + 2;
    localparam int unsigned SEQ_W = $clog2(SEQ_DEPTH);

    logic [7:0]       port_q [NPORTS];
    logic [7:0]       port_d [NPORTS];
    logic [7:0]       seq_q  [SEQ_DEPTH];
    logic [7:0]       seq_d  [SEQ_DEPTH];
    logic [SEQ_W-1:0] idx_run;
    logic [SEQ_W-1:0] idx_rd;
    logic [PW-1:0]    p;

    assign idx_rd = port_q[IDX_OFS][SEQ_W-1:0];

    // Walk the byte lanes in order: build read data and next state.
    always_comb begin
        port_d  = port_q;
        seq_d   = seq_q;
        idx_run = idx_rd;
        rdata   = '0;
        p       = '0;
        for (int k = 0; k < int'(LANES); k++) begin
            p = PW'(ofs) + PW'(k);
            if (k < int'(size) && p < PW'(NPORTS)) begin
                if (p == PW'(DATA_OFS)) begin
                    rdata[8*k +: 8] = seq_q[idx_rd];
                end else begin
                    rdata[8*k +: 8] = port_q[p[OFS_W-1:0]];
                end
                if (wr_en) begin
                    if (p == PW'(DATA_OFS)) begin
                        seq_d[idx_run] = wdata[8*k +: 8];
                    end else begin
                        port_d[p[OFS_W-1:0]] = wdata[8*k +: 8];
                        if (p == PW'(IDX_OFS)) begin
                            idx_run = wdata[8*k +: SEQ_W];
                        end
                    end
                end
            end
        end
    end

    // Commit port and sequencer state; reset clears everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NPORTS); i++) begin
                port_q[i] <= '0;
            end
            for (int j = 0; j < int'(SEQ_DEPTH); j++) begin
                seq_q[j] <= '0;
            end
        end else if (wr_en) begin
            port_q <= port_d;
            seq_q  <= seq_d;
        end
    end

endmodule

// File: rtl/disp_idx_file.sv
// Directly addressed indexed register file: NREGS registers of 16 bits.
// The index arrives already halved (byte offset >> 1). Indices at or
// above NREGS read zero and ignore writes.
module disp_idx_file #(
    parameter int unsigned NREGS = 16,
    parameter int unsigned IW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [15:0]   wdata,
    output logic [31:0]   rdata
);
    localparam int unsigned RW = $clog2(NREGS);

    logic [15:0] regs_q [NREGS];
    logic        in_range;

    assign in_range = idx < IW'(NREGS);

    // Read path: zero-extend the selected register, zero when out of range.
    always_comb begin
        rdata = '0;
        if (in_range) begin
            rdata[15:0] = regs_q[idx[RW-1:0]];
        end
    end

    // Write path: store the low half-word into the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NREGS); i++) begin
                regs_q[i] <= '0;
            end
        end else if (wr_en && in_range) begin
            regs_q[idx[RW-1:0]] <= wdata;
        end
    end

endmodule

// File: rtl/disp_ext_regs.sv
// Extension register set: a read-only span register and the byte-order
// register. Only 4-byte accesses are honoured; others read zero.
module disp_ext_regs #(
    parameter logic [31:0] EXT_SPAN = 32'h100,
    parameter logic [7:0]  SPAN_OFS = 8'h00,
    parameter logic [7:0]  BO_OFS   = 8'h04
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hit,
    input  logic        we,
    input  logic [7:0]  ofs,
    input  logic [2:0]  size,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        big_endian
);
    import disp_win_pkg::*;

    logic full_word;

    assign full_word = (size == 3'd4);

    // Read decode of the two defined offsets.
    always_comb begin
        rdata = '0;
        if (full_word && ofs == SPAN_OFS) begin
            rdata = EXT_SPAN;
        end else if (full_word && ofs == BO_OFS) begin
            rdata = big_endian ? BO_BIG_CODE : BO_LITTLE_CODE;
        end
    end

    // Byte-order flag: changes only on an exact code match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            big_endian <= 1'b0;
        end else if (hit && we && full_word && ofs == BO_OFS) begin
            if (wdata == BO_BIG_CODE) begin
                big_endian <= 1'b1;
            end else if (wdata == BO_LITTLE_CODE) begin
                big_endian <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/disp_win_decode.sv
// Top: decodes one register window into identification bytes, legacy
// ports, indexed registers and extension registers, and registers the
// read data. Assumes one-cycle strobes with sizes of 1, 2 or 4 bytes.
module disp_win_decode #(
    parameter int unsigned ADDR_W    = 12,
    parameter bit          EXT_EN    = 1'b1,
    parameter bit          ID_EN     = 1'b1,
    parameter int unsigned ID_BYTES  = 384,
    parameter int unsigned PORT_BASE = 'h400,
    parameter int unsigned NPORTS    = 32,
    parameter int unsigned IDX_BASE  = 'h500,
    parameter int unsigned IDX_SPAN  = 'h100,
    parameter int unsigned NREGS     = 16,
    parameter int unsigned EXT_BASE  = 'h600,
    parameter int unsigned EXT_SPAN  = 'h100,
    parameter logic [7:0]  BASE_REV  = 8'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              fb_big_endian,
    output logic [7:0]        dev_revision
);
    import disp_win_pkg::*;

    localparam int unsigned POFS_W = $clog2(NPORTS);
    localparam int unsigned IOFS_W = $clog2(IDX_SPAN);

    logic [31:0] a32;
    win_e        win;
    logic [31:0] port_rdata, idx_rdata, ext_rdata, id_rdata, mux_rdata;
    logic [31:0] port_rel, idx_rel, ext_rel;

    assign a32          = 32'(bus_addr);
    assign port_rel     = a32 - 32'(PORT_BASE);
    assign idx_rel      = a32 - 32'(IDX_BASE);
    assign ext_rel      = a32 - 32'(EXT_BASE);
    assign dev_revision = EXT_EN ? 8'd2 : BASE_REV;

    // Window decode; disabled windows decode as holes.
    always_comb begin
        win = WIN_NONE;
        if (ID_EN && a32 < 32'(ID_BYTES)) begin
            win = WIN_ID;
        end else if (a32 >= 32'(PORT_BASE) && a32 < 32'(PORT_BASE + NPORTS)) begin
            win = WIN_PORT;
        end else if (a32 >= 32'(IDX_BASE) && a32 < 32'(IDX_BASE + IDX_SPAN)) begin
            win = WIN_IDX;
        end else if (EXT_EN && a32 >= 32'(EXT_BASE) && a32 < 32'(EXT_BASE + EXT_SPAN)) begin
            win = WIN_EXT;
        end
    end

    disp_port_file #(
        .NPORTS(NPORTS)
    ) u_ports (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_valid && bus_we && win == WIN_PORT),
        .ofs   (port_rel[POFS_W-1:0]),
        .size  (bus_size),
        .wdata (bus_wdata),
        .rdata (port_rdata)
    );

    disp_idx_file #(
        .NREGS (NREGS),
        .IW    (IOFS_W - 1)
    ) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_valid && bus_we && win == WIN_IDX),
        .idx   (idx_rel[IOFS_W-1:1]),
        .wdata (bus_wdata[15:0]),
        .rdata (idx_rdata)
    );

    generate
        if (EXT_EN) begin : g_ext
            disp_ext_regs #(
                .EXT_SPAN (32'(EXT_SPAN))
            ) u_ext (
                .clk        (clk),
                .rst_n      (rst_n),
                .hit        (bus_valid && win == WIN_EXT),
                .we         (bus_we),
                .ofs        (ext_rel[7:0]),
                .size       (bus_size),
                .wdata      (bus_wdata),
                .rdata      (ext_rdata),
                .big_endian (fb_big_endian)
            );
        end else begin : g_no_ext
            assign ext_rdata     = '0;
            assign fb_big_endian = 1'b0;
        end

        if (ID_EN) begin : g_id
            // Identification read: generate each lane's byte from its address.
            always_comb begin
                id_rdata = '0;
                for (int k = 0; k < int'(LANES); k++) begin
                    if (k < int'(bus_size) && (a32 + 32'(k)) < 32'(ID_BYTES)) begin
                        id_rdata[8*k +: 8] = id_byte(a32 + 32'(k));
                    end
                end
            end
        end else begin : g_no_id
            assign id_rdata = '0;
        end
    endgenerate

    // Read data select by window.
    always_comb begin
        case (win)
            WIN_ID:   mux_rdata = id_rdata;
            WIN_PORT: mux_rdata = port_rdata;
            WIN_IDX:  mux_rdata = idx_rdata;
            WIN_EXT:  mux_rdata = ext_rdata;
            default:  mux_rdata = '0;
        endcase
    end

    // Read data register: loads on a read strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_valid && !bus_we) begin
            bus_rdata <= mux_rdata;
        end
    end

endmodule

// File: rtl/disp_win_decode_chk.sv
// Checker: temporal properties of the byte-order flag and read data path.
// Assumes one-cycle strobes; attached to every top instance by bind.
module disp_win_decode_chk #(
    parameter int unsigned ADDR_W  = 12,
    parameter bit          EXT_EN  = 1'b1,
    parameter int unsigned BO_ADDR = 'h604,
    parameter int unsigned HOLE_LO = 'h700
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [2:0]        bus_size,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              fb_big_endian
);
    import disp_win_pkg::*;

    logic bo_acc, bo_wr, rd;

    assign rd     = bus_valid && !bus_we;
    assign bo_acc = EXT_EN && bus_valid && bus_size == 3'd4 &&
                    32'(bus_addr) == 32'(BO_ADDR);
    assign bo_wr  = bo_acc && bus_we;

    p_bo_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bo_wr && bus_wdata == BO_BIG_CODE |=> fb_big_endian);

    p_bo_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bo_wr && bus_wdata == BO_LITTLE_CODE |=> !fb_big_endian);

    p_bo_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bo_wr && (bus_wdata == BO_BIG_CODE || bus_wdata == BO_LITTLE_CODE))
        |=> $stable(fb_big_endian));

    p_bo_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bo_acc && !bus_we |=>
        bus_rdata == ($past(fb_big_endian) ? BO_BIG_CODE : BO_LITTLE_CODE));

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata));

    p_hole_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd && 32'(bus_addr) >= 32'(HOLE_LO) |=> bus_rdata == 32'd0);

endmodule

bind disp_win_decode disp_win_decode_chk #(
    .ADDR_W  (ADDR_W),
    .EXT_EN  (EXT_EN),
    .BO_ADDR (EXT_BASE + 4),
    .HOLE_LO (EXT_BASE + EXT_SPAN)
) u_chk (.*);

// File: tb/disp_win_decode_tb.sv
`timescale 1ns/1ps
module disp_win_decode_tb;

    typedef struct packed {
        logic        we;
        logic [11:0] addr;
        logic [2:0]  size;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 43;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h400, 3'd1, 32'h0000_005A, 32'h0,         8'd1},
        '{1'b0, 12'h400, 3'd1, 32'h0,         32'h0000_005A, 8'd1},  // R1
        '{1'b1, 12'h402, 3'd2, 32'h0000_BBAA, 32'h0,         8'd1},
        '{1'b0, 12'h402, 3'd1, 32'h0,         32'h0000_00AA, 8'd1},  // R1
        '{1'b0, 12'h403, 3'd1, 32'h0,         32'h0000_00BB, 8'd1},  // R1
        '{1'b0, 12'h401, 3'd4, 32'h0,         32'h00BB_AA00, 8'd2},  // R2
        '{1'b1, 12'h404, 3'd2, 32'h0000_7703, 32'h0,         8'd3},
        '{1'b0, 12'h405, 3'd1, 32'h0,         32'h0000_0077, 8'd3},  // R3
        '{1'b0, 12'h404, 3'd1, 32'h0,         32'h0000_0003, 8'd3},  // R3
        '{1'b1, 12'h404, 3'd1, 32'h0000_0001, 32'h0,         8'd3},
        '{1'b1, 12'h405, 3'd1, 32'h0000_0044, 32'h0,         8'd3},
        '{1'b0, 12'h404, 3'd2, 32'h0,         32'h0000_4401, 8'd3},  // R3
        '{1'b1, 12'h404, 3'd1, 32'h0000_0003, 32'h0,         8'd3},
        '{1'b0, 12'h405, 3'd1, 32'h0,         32'h0000_0077, 8'd3},  // R3
        '{1'b1, 12'h41F, 3'd2, 32'h0000_1234, 32'h0,         8'd2},
        '{1'b0, 12'h41E, 3'd4, 32'h0,         32'h0000_3400, 8'd2},  // R2
        '{1'b1, 12'h506, 3'd2, 32'h0000_CAFE, 32'h0,         8'd4},
        '{1'b0, 12'h506, 3'd2, 32'h0,         32'h0000_CAFE, 8'd4},  // R4
        '{1'b0, 12'h507, 3'd2, 32'h0,         32'h0000_CAFE, 8'd4},  // R4
        '{1'b1, 12'h5FE, 3'd2, 32'h0000_1111, 32'h0,         8'd4},
        '{1'b0, 12'h5FE, 3'd2, 32'h0,         32'h0,         8'd4},  // R4
        '{1'b0, 12'h504, 3'd2, 32'h0,         32'h0,         8'd4},  // R4
        '{1'b0, 12'h600, 3'd4, 32'h0,         32'h0000_0100, 8'd5},  // R5
        '{1'b0, 12'h604, 3'd4, 32'h0,         32'h1E1E_1E1E, 8'd6},  // R6
        '{1'b1, 12'h604, 3'd4, 32'hBEBE_BEBE, 32'h0,         8'd7},
        '{1'b0, 12'h604, 3'd4, 32'h0,         32'hBEBE_BEBE, 8'd6},  // R6
        '{1'b1, 12'h604, 3'd4, 32'h1234_5678, 32'h0,         8'd7},
        '{1'b0, 12'h604, 3'd4, 32'h0,         32'hBEBE_BEBE, 8'd7},  // R7
        '{1'b1, 12'h604, 3'd2, 32'h1E1E_1E1E, 32'h0,         8'd8},
        '{1'b0, 12'h604, 3'd4, 32'h0,         32'hBEBE_BEBE, 8'd8},  // R8
        '{1'b0, 12'h604, 3'd2, 32'h0,         32'h0,         8'd8},  // R8
        '{1'b1, 12'h604, 3'd4, 32'h1E1E_1E1E, 32'h0,         8'd7},
        '{1'b0, 12'h604, 3'd4, 32'h0,         32'h1E1E_1E1E, 8'd7},  // R7
        '{1'b0, 12'h608, 3'd4, 32'h0,         32'h0,         8'd5},  // R5
        '{1'b0, 12'h000, 3'd4, 32'h0,         32'hFFFF_FF00, 8'd9},  // R9
        '{1'b0, 12'h008, 3'd1, 32'h0,         32'h0000_0033, 8'd9},  // R9
        '{1'b1, 12'h008, 3'd1, 32'h0000_00AA, 32'h0,         8'd9},
        '{1'b0, 12'h008, 3'd1, 32'h0,         32'h0000_0033, 8'd9},  // R9
        '{1'b0, 12'h17F, 3'd4, 32'h0,         32'h0000_0066, 8'd9},  // R9
        '{1'b0, 12'h180, 3'd1, 32'h0,         32'h0,         8'd11}, // R11
        '{1'b0, 12'h420, 3'd1, 32'h0,         32'h0,         8'd11}, // R11
        '{1'b1, 12'h700, 3'd4, 32'hDEAD_BEEF, 32'h0,         8'd11},
        '{1'b0, 12'h700, 3'd4, 32'h0,         32'h0,         8'd11}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [2:0]  bus_size = 3'd1;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, off_rdata;
    logic        fb_big_endian, off_big_endian;
    logic [7:0]  dev_revision, off_revision;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    disp_win_decode u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .fb_big_endian(fb_big_endian),
        .dev_revision(dev_revision)
    );

    disp_win_decode #(.EXT_EN(1'b0), .ID_EN(1'b0)) u_off (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(off_rdata), .fb_big_endian(off_big_endian),
        .dev_revision(off_revision)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // One-cycle strobe; the registered read data is valid afterwards.
    task automatic access(input logic we, input logic [11:0] addr,
                          input logic [2:0] size, input logic [31:0] wdata);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_we    = we;
        bus_addr  = addr;
        bus_size  = size;
        bus_wdata = wdata;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_we    = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check("R12 rdata after reset", bus_rdata, 32'h0);
        check("R12 flag after reset", 32'(fb_big_endian), 32'h0);
        check("R10 revision with extension", 32'(dev_revision), 32'd2);
        check("R10 revision without extension", 32'(off_revision), 32'd1);
        access(1'b0, 12'h405, 3'd1, 32'h0);
        check("R1 port reads zero after reset", bus_rdata, 32'h0);

        for (int v = 0; v < NV; v++) begin
            access(VECS[v].we, VECS[v].addr, VECS[v].size, VECS[v].wdata);
            if (!VECS[v].we) begin
                check($sformatf("R%0d vector %0d", VECS[v].req, v), bus_rdata, VECS[v].exp);
            end
        end

        // R7: flag output follows exact codes only
        access(1'b1, 12'h604, 3'd4, 32'hBEBE_BEBE);
        check("R7 flag set by big code", 32'(fb_big_endian), 32'h1);
        access(1'b1, 12'h604, 3'd4, 32'hBEBE_BEBF);
        check("R7 flag kept on near-miss", 32'(fb_big_endian), 32'h1);
        access(1'b1, 12'h604, 3'd4, 32'h1E1E_1E1E);
        check("R7 flag cleared by little code", 32'(fb_big_endian), 32'h0);

        // R12: read data holds across write and idle cycles
        access(1'b0, 12'h600, 3'd4, 32'h0);
        access(1'b1, 12'h400, 3'd1, 32'h0000_0011);
        repeat (2) @(negedge clk);
        check("R12 rdata held after write", bus_rdata, 32'h0000_0100);

        // R10: disabled windows on the second instance
        access(1'b1, 12'h604, 3'd4, 32'hBEBE_BEBE);
        check("R10 disabled flag stays clear", 32'(off_big_endian), 32'h0);
        access(1'b0, 12'h604, 3'd4, 32'h0);
        check("R10 disabled extension reads zero", off_rdata, 32'h0);
        access(1'b0, 12'h000, 3'd4, 32'h0);
        check("R10 disabled identification reads zero", off_rdata, 32'h0);
        check("R9 identification still on main instance", bus_rdata, 32'hFFFF_FF00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule